// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol front end of a byte-addressed serial EEPROM. It watches the serial clock and data lines with the system clock and passes both through two-flop synchronizers. It finds start and stop conditions, shifts bytes in and out most significant bit first, and pulls the data line low to acknowledge. It then steps through the transaction: device select byte, two word-address bytes, data bytes. Each received data byte goes out on a one-cycle strobe to an external page buffer. A stop that follows written data raises a commit pulse, which starts the external write cycle. Read data comes from the array through a combinational address/data pair.

The device select byte carries a fixed prefix, three strap bits that must match `dev_sel_i`, and a direction bit. While the external write cycle reports busy, the select byte gets no acknowledge, so a master can poll for completion. A random read is a write that carries only the word address, followed by a repeated start and a read. A read goes on byte after byte for as long as the master acknowledges. The data line is modelled as a separate input and an active-high pull-down request. The caller builds the wired-AND from these.

Top module: `tws_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) in any state drops the current transfer and begins a new device select byte. A byte that was only partly received is neither strobed nor stored.
- R2: The select byte is received MSB first as 1010, then the three strap bits, then the direction bit (1 = read). On a match the block pulls SDA low for the ninth clock of the byte.
- R3: A select byte whose prefix or strap bits differ gets no acknowledge. Every following byte is ignored until the next start: no strobe, no commit, no pull.
- R4: A write carries a high and a low word-address byte, and each is acknowledged. The pointer takes the low ADDR_W bits of the 16-bit value, and the higher bits are ignored.
- R5: Each acknowledged data byte gives a one-cycle `wr_stb_o` with the pointer address and the byte. The lower PAGE_W pointer bits then advance and wrap inside the page, and the upper bits stay the same.
- R6: A stop (SDA rising while SCL is high) after at least one data byte gives exactly one `wr_commit_o` pulse, in the cycle after the stop is detected. A stop with no data byte gives none.
- R7: While `busy_i` is high, a matching select byte is not acknowledged. Once `busy_i` is low it is acknowledged again.
- R8: A read returns the byte at the pointer, and the pointer then advances by one and wraps over the whole address space. A read with no word address starts from the last accessed address plus one.
- R9: A write select, two word-address bytes, a repeated start and a read select return the byte at the given address. This sequence produces no strobe and no commit.
- R10: After the master leaves a read byte unacknowledged, the block stops driving SDA and ignores further clocks until a start.
- R11: The block samples incoming bits on SCL rising edges and changes its SDA pull only while SCL is low.
- R12: During and right after reset, `sda_pull_o`, `wr_stb_o` and `wr_commit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 3 | Strap bits compared with the select byte |
| busy_i | input | 1 | External write cycle in progress |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| wr_stb_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse that starts the write cycle |
| rd_addr_o | output | ADDR_W | Current address pointer, for the array read |
| rd_data_i | input | 8 | Array data at `rd_addr_o` |

## Verification
A wrong bit count or state shows up within one byte, because the acknowledge slot falls on the wrong clock and the master samples a missing or early ACK on the ninth bit. Pointer errors show up as wrong strobe addresses during a page write, or as the wrong byte on the very next read. Sweeping the page across its wrap point and the read across the top of the address space catches wrap faults at once. A fault in busy or commit handling changes the result of the first poll after a stop.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WAH,
    ST_WAL,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d[g];
        sync_q <= meta_q;
      end
    end
    assign q[g] = sync_q;
  end
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high are bus conditions, not data.
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_xfer_fsm.sv
module tws_xfer_fsm
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        dev_sel,
  input  logic              busy,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int HI_W = ADDR_W - 8;

  tws_state_e        state_q, state_n, ret_q, ret_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [7:0]        rx_q, rx_n, tx_q, tx_n, wdata_q, wdata_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, waddr_q, waddr_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic              pend_q, pend_n, mack_q, mack_n;
  logic              pull_q, pull_n, stb_q, stb_n, commit_q, commit_n;

  logic              byte_full, addr_hit;
  logic [PAGE_W-1:0] ofs_next;
  logic [ADDR_W-1:0] page_next;

  assign byte_full = (cnt_q == 4'd8);
  assign addr_hit  = (rx_q[7:1] == {DEV_PREFIX, dev_sel});
  assign ofs_next  = ptr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
  assign page_next = {ptr_q[ADDR_W-1:PAGE_W], ofs_next};

  always_comb begin
    state_n  = state_q;
    ret_n    = ret_q;
    cnt_n    = cnt_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    ptr_n    = ptr_q;
    hi_n     = hi_q;
    pend_n   = pend_q;
    mack_n   = mack_q;
    pull_n   = pull_q;
    waddr_n  = waddr_q;
    wdata_n  = wdata_q;
    stb_n    = 1'b0;
    commit_n = 1'b0;
    if (start_evt) begin
      state_n = ST_DEV;
      cnt_n   = 4'd0;
      pull_n  = 1'b0;
      pend_n  = 1'b0;
    end else if (stop_evt) begin
      state_n  = ST_IDLE;
      pull_n   = 1'b0;
      commit_n = pend_q;
      pend_n   = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WAH, ST_WAL, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            rx_n  = {rx_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && byte_full) begin
            state_n = ST_ACK;
            pull_n  = 1'b1;
            cnt_n   = 4'd0;
            case (state_q)
              ST_DEV: begin
                if (addr_hit && !busy) begin
                  ret_n = rx_q[0] ? ST_RDAT : ST_WAH;
                end else begin
                  state_n = ST_IDLE;
                  pull_n  = 1'b0;
                end
              end
              ST_WAH: begin
                hi_n  = rx_q[HI_W-1:0];
                ret_n = ST_WAL;
              end
              ST_WAL: begin
                ptr_n = {hi_q, rx_q};
                ret_n = ST_WDAT;
              end
              default: begin
                stb_n   = 1'b1;
                waddr_n = ptr_q;
                wdata_n = rx_q;
                ptr_n   = page_next;
                pend_n  = 1'b1;
                ret_n   = ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_n = ret_q;
            cnt_n   = 4'd0;
            pull_n  = 1'b0;
            if (ret_q == ST_RDAT) begin
              tx_n   = rd_data;
              pull_n = ~rd_data[7];
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise && !byte_full) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (byte_full) begin
              state_n = ST_RACK;
              pull_n  = 1'b0;
              ptr_n   = ptr_q + ADDR_W'(1);
              mack_n  = 1'b0;
            end else begin
              tx_n   = {tx_q[6:0], 1'b0};
              pull_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n = ST_RDAT;
              cnt_n   = 4'd0;
              tx_n    = rd_data;
              pull_n  = ~rd_data[7];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ret_q    <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      hi_q     <= '0;
      pend_q   <= 1'b0;
      mack_q   <= 1'b0;
      pull_q   <= 1'b0;
      stb_q    <= 1'b0;
      commit_q <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_n;
      ret_q    <= ret_n;
      cnt_q    <= cnt_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      ptr_q    <= ptr_n;
      hi_q     <= hi_n;
      pend_q   <= pend_n;
      mack_q   <= mack_n;
      pull_q   <= pull_n;
      stb_q    <= stb_n;
      commit_q <= commit_n;
      waddr_q  <= waddr_n;
      wdata_q  <= wdata_n;
    end
  end

  assign sda_pull  = pull_q;
  assign wr_stb    = stb_q;
  assign wr_addr   = waddr_q;
  assign wr_data   = wdata_q;
  assign wr_commit = commit_q;
  assign rd_addr   = ptr_q;
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        dev_sel_i,
  input  logic              busy_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_evt, stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tws_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({scl_i, sda_i}),
    .q     (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  tws_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tws_xfer_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dev_sel   (dev_sel_i),
    .busy      (busy_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .rd_data   (rd_data_i),
    .sda_pull  (sda_pull_o),
    .wr_stb    (wr_stb_o),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o),
    .wr_commit (wr_commit_o),
    .rd_addr   (rd_addr_o)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_pull,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit
);
  logic              have_prev_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [PAGE_W-1:0] exp_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      last_addr_q <= '0;
    end else if (start_evt || stop_evt) begin
      have_prev_q <= 1'b0;
    end else if (wr_stb) begin
      have_prev_q <= 1'b1;
      last_addr_q <= wr_addr;
    end
  end
  assign exp_ofs = last_addr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};

  // R11: pull moves only with SCL low, apart from start/stop release
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull != $past(sda_pull)) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  // R6: commit follows a stop by one cycle
  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_stb_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && have_prev_q) |-> (wr_addr[ADDR_W-1:PAGE_W] == last_addr_q[ADDR_W-1:PAGE_W]));

  assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && have_prev_q) |-> (wr_addr[PAGE_W-1:0] == exp_ofs));
endmodule

bind tws_eeprom_slave tws_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_pull  (sda_pull_o),
  .wr_stb    (wr_stb_o),
  .wr_addr   (wr_addr_o),
  .wr_commit (wr_commit_o)
);

// File: tb/tb_tws_eeprom_slave.sv
module tb_tws_eeprom_slave;
  localparam int AW = 9;
  localparam int PW = 3;
  localparam int MEM_N = 1 << AW;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk, rst_n, scl_m, sda_m, busy;
  logic sda_pull, wr_stb, wr_commit, sda_line;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [MEM_N];
  logic [7:0] model [MEM_N];
  logic [AW-1:0] stb_a [64];
  logic [7:0] stb_d [64];
  int stb_cnt, commit_cnt, busy_cnt, pull_cycles, bad_toggle;
  int checks, errors;
  logic pull_q;

  assign sda_line = sda_m & ~sda_pull;
  assign busy = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  tws_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .dev_sel_i(STRAP), .busy_i(busy),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (wr_stb) begin
      mem[wr_addr] <= wr_data;
      if (stb_cnt < 64) begin
        stb_a[stb_cnt] <= wr_addr;
        stb_d[stb_cnt] <= wr_data;
      end
      stb_cnt <= stb_cnt + 1;
    end
    if (wr_commit) begin
      commit_cnt <= commit_cnt + 1;
      busy_cnt <= 2000;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (sda_pull) pull_cycles <= pull_cycles + 1;
    if ((sda_pull != pull_q) && scl_m) bad_toggle <= bad_toggle + 1;
    pull_q <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clock_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    clock_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = master_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [AW-1:0] a;
    checks = 0; errors = 0;
    stb_cnt = 0; commit_cnt = 0; busy_cnt = 0; pull_cycles = 0; bad_toggle = 0;
    pull_q = 1'b0;
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    tick(5);
    // R12: outputs quiet in reset
    chk(!sda_pull && !wr_stb && !wr_commit, "R12 reset", {sda_pull, wr_stb, wr_commit}, 0);
    rst_n = 1'b1;
    tick(6);
    chk(!sda_pull && !wr_stb && !wr_commit, "R12 after reset", {sda_pull, wr_stb, wr_commit}, 0);

    // R3: wrong strap bits get no ack, following bytes ignored
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    chk(!ack, "R3 mismatch nack", ack, 0);
    pull_cycles = 0;
    send_byte(8'h00, ack);
    send_byte(8'h05, ack);
    send_byte(8'h77, ack);
    bus_stop(); tick(4);
    chk(stb_cnt == 0 && commit_cnt == 0 && pull_cycles == 0, "R3 ignored",
        stb_cnt + commit_cnt + pull_cycles, 0);

    // R2 R4 R5: page write with excess word-address bits and page wrap
    bus_start();
    send_byte(DEV_W, ack);
    chk(ack, "R2 select ack", ack, 1);
    send_byte(8'hA5, ack);
    chk(ack, "R4 high address ack", ack, 1);
    send_byte(8'h15, ack);
    chk(ack, "R4 low address ack", ack, 1);
    for (int k = 0; k < 10; k++) begin
      send_byte(8'(k * 13 + 64), ack);
      chk(ack, "R5 data ack", ack, 1);
    end
    bus_stop(); tick(4);
    chk(stb_cnt == 10, "R5 strobe count", stb_cnt, 10);
    for (int k = 0; k < 10; k++) begin
      a = AW'(9'h110 | ((5 + k) % 8));
      model[a] = 8'(k * 13 + 64);
      chk(stb_a[k] == a, "R5 R4 strobe address", stb_a[k], a);
      chk(stb_d[k] == 8'(k * 13 + 64), "R5 strobe data", stb_d[k], 8'(k * 13 + 64));
    end
    chk(commit_cnt == 1, "R6 commit once", commit_cnt, 1);

    // R7: polling while busy
    bus_start();
    send_byte(DEV_W, ack);
    chk(!ack, "R7 busy nack", ack, 0);
    bus_stop();
    while (busy) tick(1);
    tick(2);
    bus_start();
    send_byte(DEV_W, ack);
    chk(ack, "R7 ready ack", ack, 1);
    bus_stop(); tick(4);
    chk(commit_cnt == 1, "R6 no commit without data", commit_cnt, 1);

    // R9: random read through a write with only the word address
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h01, ack);
    send_byte(8'h12, ack);
    bus_start();
    send_byte(DEV_R, ack);
    chk(ack, "R2 read select ack", ack, 1);
    recv_byte(1'b0, rb);
    chk(rb == model[9'h112], "R9 random read", rb, model[9'h112]);
    bus_stop(); tick(4);
    chk(stb_cnt == 10 && commit_cnt == 1, "R9 no write side effects", stb_cnt, 10);

    // R8: current address read continues from last+1
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, rb);
    chk(rb == model[9'h113], "R8 current read", rb, model[9'h113]);
    bus_stop();

    // R8: sequential read across the top of the address space
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h01, ack);
    send_byte(8'hFD, ack);
    bus_start();
    send_byte(DEV_R, ack);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i < 4, rb);
      a = AW'((9'h1FD + i) % MEM_N);
      chk(rb == model[a], "R8 sequential read", rb, model[a]);
    end

    // R10: after master nack, further clocks get no response
    pull_cycles = 0;
    for (int i = 0; i < 9; i++) clock_bits(8'hFF, 1);
    chk(pull_cycles == 0, "R10 released after nack", pull_cycles, 0);
    bus_stop();

    // R1: start mid-byte aborts the partial byte
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h00, ack);
    send_byte(8'h30, ack);
    clock_bits(8'hC3, 4);
    bus_start();
    send_byte(DEV_R, ack);
    chk(ack, "R1 restart select ack", ack, 1);
    recv_byte(1'b0, rb);
    chk(rb == model[9'h030], "R1 read after abort", rb, model[9'h030]);
    bus_stop(); tick(4);
    chk(stb_cnt == 10 && commit_cnt == 1, "R1 aborted byte not strobed", stb_cnt, 10);

    // R11: no pull change while SCL high
    chk(bad_toggle == 0, "R11 pull timing", bad_toggle, 0);
    finish_run();
  end
endmodule